// File: doc/BRIEF.md
# Four-Core Power-Down and WFI Gating Controller

This block is a small memory-mapped control unit for a cluster of four processor cores. Software programs it over a 32-bit register bus with word-aligned accesses. It keeps a 64-bit reset vector base address for each core, assembled from a low and a high register. It keeps a power-down request bit for each core. It also holds a few plain configuration words and an interrupt mask with separate set and clear registers.

A power-management unit watches the gated WFI outputs. Core i's wait-for-interrupt indication reaches the power manager only while software has set that core's power-down request. Each request bit also drives a per-core power-status output. The assembled reset vectors go straight to the cores.

Top module: `cluster_pwr_ctl`

## Requirements
- R1: After reset, every low vector half reads 0xFFFF0000 and every high half reads 0. Configuration word 0 (offset 0x20) reads 0x00000F0F and the coherency word (0x60) reads 0x000F000F. The mask (0x14) reads 1 and all other registers read 0. All power-status and WFI outputs are low.
- R2: `wfi_gated[i]` is high exactly when request bit i is set and `wfi_in[i]` was high at the previous clock edge. The inputs are registered once, so a change on `wfi_in` shows one cycle later.
- R3: A write to offset 0x90 loads request bit i from write-data bit i, for i = 0..3. Write-data bits 31:4 are dropped, and a read of 0x90 returns the request bits in bits 3:0 with zeros above.
- R4: `pwr_status[i]` equals request bit i. It changes only after a write to 0x90 that changes that bit, and writing the same value leaves it steady.
- R5: Core i's low vector half lives at offset 0x40+8i and its high half at 0x44+8i. `reset_vec[64i +: 64]` equals {high, low}, and it takes a written value the cycle after the write.
- R6: At offset 0x94, the bits under mask 0x0003000F are read-only. Bits 3:0 read the request bits and bits 17:16 read 0. All other bits read back the last value written to them.
- R7: Writing 0x18 with bit 0 set clears the mask bit, and writing 0x1C with bit 0 set sets it. Writes to 0x14 are ignored. Offsets 0x10, 0x18 and 0x1C always read 0.
- R8: Offsets 0x00, 0x20, 0x24, 0x60 and 0x64 are plain 32-bit read/write registers.
- R9: `req_ready` is always high. An accepted read raises `rd_valid` for exactly one cycle, on the cycle after the request, with the data in `rd_data`.
- R10: A write with `req_addr[1:0]` nonzero changes nothing. A read with a misaligned or unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Always accepting |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| wfi_in | input | 4 | Per-core wait-for-interrupt |
| wfi_gated | output | 4 | WFI passed to the power manager |
| pwr_status | output | 4 | Per-core power-down request status |
| reset_vec | output | 256 | Four 64-bit reset vectors, core 0 in the low bits |

## Verification
The bench builds the block with its default values: four cores, an 8-bit address and the default reset words. With these values every mapped offset and every core's vector pair can be reached. All sixteen WFI input patterns can be combined with several request masks. A reference model in the bench is compared with every output on every clock. Directed reads cover the reset values, the read-only status bits, the mask set and clear registers, and misaligned accesses.

// File: rtl/cluster_pwr_ctl.sv
module cluster_pwr_ctl #(
  parameter int NCORE = 4,
  parameter int AW = 8,
  parameter logic [31:0] VEC_LO_RST = 32'hFFFF_0000,
  parameter logic [31:0] CFG0_RST = 32'h0000_0F0F,
  parameter logic [31:0] COH_RST = 32'h000F_000F,
  parameter logic [31:0] PST_RO_MASK = 32'h0003_000F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [31:0]           req_wdata,
  output logic                  req_ready,
  output logic                  rd_valid,
  output logic [31:0]           rd_data,
  input  logic [NCORE-1:0]      wfi_in,
  output logic [NCORE-1:0]      wfi_gated,
  output logic [NCORE-1:0]      pwr_status,
  output logic [NCORE*64-1:0]   reset_vec
);
  localparam logic [AW-1:0] A_ERR  = AW'(8'h00);
  localparam logic [AW-1:0] A_ISR  = AW'(8'h10);
  localparam logic [AW-1:0] A_MASK = AW'(8'h14);
  localparam logic [AW-1:0] A_UNM  = AW'(8'h18);
  localparam logic [AW-1:0] A_MSK  = AW'(8'h1C);
  localparam logic [AW-1:0] A_CFG0 = AW'(8'h20);
  localparam logic [AW-1:0] A_CFG1 = AW'(8'h24);
  localparam logic [AW-1:0] A_COH  = AW'(8'h60);
  localparam logic [AW-1:0] A_SNP  = AW'(8'h64);
  localparam logic [AW-1:0] A_PREQ = AW'(8'h90);
  localparam logic [AW-1:0] A_PST  = AW'(8'h94);
  localparam int VEC_BASE = 'h40;

  logic [31:0] err_q, cfg0_q, cfg1_q, coh_q, snp_q, pst_q;
  logic [31:0] vlo_q [NCORE];
  logic [31:0] vhi_q [NCORE];
  logic [NCORE-1:0] req_q, wfi_q;
  logic mask_q;
  logic [31:0] rd_c;

  wire aligned = (req_addr[1:0] == 2'b00);
  wire wr = req_valid & req_write & aligned;
  wire rd = req_valid & ~req_write;

  assign req_ready  = 1'b1;
  assign pwr_status = req_q;
  assign wfi_gated  = req_q & wfi_q;

  generate
    for (genvar g = 0; g < NCORE; g++) begin : g_vec
      assign reset_vec[g*64 +: 64] = {vhi_q[g], vlo_q[g]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= '0; cfg0_q <= CFG0_RST; cfg1_q <= '0;
      coh_q <= COH_RST; snp_q <= '0; pst_q <= '0;
      req_q <= '0; wfi_q <= '0; mask_q <= 1'b1;
      for (int i = 0; i < NCORE; i++) begin
        vlo_q[i] <= VEC_LO_RST;
        vhi_q[i] <= '0;
      end
    end else begin
      wfi_q <= wfi_in;
      if (wr) begin
        case (req_addr)
          A_ERR:  err_q  <= req_wdata;
          A_CFG0: cfg0_q <= req_wdata;
          A_CFG1: cfg1_q <= req_wdata;
          A_COH:  coh_q  <= req_wdata;
          A_SNP:  snp_q  <= req_wdata;
          A_PREQ: req_q  <= req_wdata[NCORE-1:0];
          A_PST:  pst_q  <= req_wdata & ~PST_RO_MASK;
          A_UNM:  if (req_wdata[0]) mask_q <= 1'b0;
          A_MSK:  if (req_wdata[0]) mask_q <= 1'b1;
          default: ;
        endcase
        for (int i = 0; i < NCORE; i++) begin
          if (req_addr == AW'(VEC_BASE + 8*i))     vlo_q[i] <= req_wdata;
          if (req_addr == AW'(VEC_BASE + 8*i + 4)) vhi_q[i] <= req_wdata;
        end
      end
    end
  end

  always_comb begin
    rd_c = '0;
    case (req_addr)
      A_ERR:  rd_c = err_q;
      A_ISR:  rd_c = '0;
      A_MASK: rd_c = {31'b0, mask_q};
      A_CFG0: rd_c = cfg0_q;
      A_CFG1: rd_c = cfg1_q;
      A_COH:  rd_c = coh_q;
      A_SNP:  rd_c = snp_q;
      A_PREQ: rd_c = 32'(req_q);
      A_PST:  rd_c = (pst_q & ~PST_RO_MASK) | 32'(req_q);
      default: ;
    endcase
    for (int i = 0; i < NCORE; i++) begin
      if (req_addr == AW'(VEC_BASE + 8*i))     rd_c = vlo_q[i];
      if (req_addr == AW'(VEC_BASE + 8*i + 4)) rd_c = vhi_q[i];
    end
    if (!aligned) rd_c = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rd_c;
    end
  end
endmodule

// File: rtl/cluster_pwr_ctl_chk.sv
module cluster_pwr_ctl_chk #(
  parameter int NCORE = 4,
  parameter int AW = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [AW-1:0]       req_addr,
  input logic                req_ready,
  input logic                rd_valid,
  input logic [NCORE-1:0]    wfi_in,
  input logic [NCORE-1:0]    wfi_gated,
  input logic [NCORE-1:0]    pwr_status,
  input logic [NCORE*64-1:0] reset_vec
);
  wire preq_wr = req_valid && req_write && (req_addr == AW'(8'h90));
  wire bad_wr  = req_valid && req_write && (req_addr[1:0] != 2'b00);
  wire rd_req  = req_valid && !req_write;

  p_wfi_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wfi_gated == (pwr_status & $past(wfi_in))));
  p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !preq_wr |=> $stable(pwr_status));
  p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  p_rd_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);
  p_misaligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> ($stable(reset_vec) && $stable(pwr_status)));
endmodule

bind cluster_pwr_ctl cluster_pwr_ctl_chk #(.NCORE(NCORE), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_ready(req_ready), .rd_valid(rd_valid),
  .wfi_in(wfi_in), .wfi_gated(wfi_gated), .pwr_status(pwr_status),
  .reset_vec(reset_vec)
);

// File: tb/tb_cluster_pwr_ctl.sv
module tb_cluster_pwr_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rd_valid;
  logic [31:0] rd_data;
  logic [NC-1:0] wfi_in = 0, wfi_gated, pwr_status;
  logic [NC*64-1:0] reset_vec;

  int checks = 0, fails = 0;
  bit done = 0;

  cluster_pwr_ctl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  bit [31:0] m_err, m_cfg0, m_cfg1, m_coh, m_snp, m_pst;
  bit [31:0] m_lo [NC];
  bit [31:0] m_hi [NC];
  bit [3:0] m_req, m_wfi;
  bit m_mask, m_rdv;
  bit [31:0] m_rdd;

  function automatic bit [31:0] mread(input bit [7:0] a);
    if (a[1:0] != 0) return 0;
    if (a >= 8'h40 && a < 8'h60) begin
      int k = (a - 8'h40) / 8;
      return a[2] ? m_hi[k] : m_lo[k];
    end
    case (a)
      8'h00: return m_err;
      8'h14: return {31'b0, m_mask};
      8'h20: return m_cfg0;
      8'h24: return m_cfg1;
      8'h60: return m_coh;
      8'h64: return m_snp;
      8'h90: return {28'b0, m_req};
      8'h94: return (m_pst & 32'hFFFC_FFF0) | {28'b0, m_req};
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_err = 0; m_cfg0 = 32'hF0F; m_cfg1 = 0; m_coh = 32'h000F000F; m_snp = 0;
      m_pst = 0; m_req = 0; m_wfi = 0; m_mask = 1; m_rdv = 0; m_rdd = 0;
      for (int i = 0; i < NC; i++) begin m_lo[i] = 32'hFFFF0000; m_hi[i] = 0; end
    end else begin
      m_rdv = req_valid && !req_write;
      if (m_rdv) m_rdd = mread(req_addr);
      m_wfi = wfi_in;
      if (req_valid && req_write && req_addr[1:0] == 0) begin
        if (req_addr >= 8'h40 && req_addr < 8'h60) begin
          if (req_addr[2]) m_hi[(req_addr - 8'h40) / 8] = req_wdata;
          else m_lo[(req_addr - 8'h40) / 8] = req_wdata;
        end
        case (req_addr)
          8'h00: m_err = req_wdata;
          8'h20: m_cfg0 = req_wdata;
          8'h24: m_cfg1 = req_wdata;
          8'h60: m_coh = req_wdata;
          8'h64: m_snp = req_wdata;
          8'h90: m_req = req_wdata[3:0];
          8'h94: m_pst = req_wdata;
          8'h18: if (req_wdata[0]) m_mask = 0;
          8'h1C: if (req_wdata[0]) m_mask = 1;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [255:0] ev;
      for (int i = 0; i < NC; i++) ev[i*64 +: 64] = {m_hi[i], m_lo[i]};
      chk(wfi_gated === (m_req & m_wfi), "R2 wfi_gated", 256'(wfi_gated), 256'(m_req & m_wfi));
      chk(pwr_status === m_req, "R4 pwr_status", 256'(pwr_status), 256'(m_req));
      chk(reset_vec === ev, "R5 reset_vec", reset_vec, ev);
      chk(rd_valid === m_rdv, "R9 rd_valid", 256'(rd_valid), 256'(m_rdv));
      if (m_rdv) chk(rd_data === m_rdd, "R9 rd_data", 256'(rd_data), 256'(m_rdd));
      chk(req_ready === 1'b1, "R9 req_ready", 256'(req_ready), 256'(1));
    end
  end

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input bit [7:0] a, input bit [31:0] exp, input string tag);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    #1;
    chk(rd_valid === 1'b1 && rd_data === exp, tag, 256'(rd_data), 256'(exp));
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    chk(pwr_status === 0 && wfi_gated === 0, "R1 outputs after reset", 256'({pwr_status, wfi_gated}), 256'(0));
    rst_n = 1;
    @(negedge clk);
    rd(8'h40, 32'hFFFF0000, "R1 vec0 low");
    rd(8'h5C, 32'h0, "R1 vec3 high");
    rd(8'h20, 32'h00000F0F, "R1 cfg0");
    rd(8'h60, 32'h000F000F, "R1 coherency");
    rd(8'h14, 32'h1, "R1 mask");
    rd(8'h00, 32'h0, "R1 err");
    rd(8'h94, 32'h0, "R1 pstat");
    // R3 request bits, upper data dropped
    wr(8'h90, 32'hFFFF_FFF5);
    rd(8'h90, 32'h5, "R3 request readback");
    // R2 all WFI patterns against several request masks
    for (int r = 0; r < 4; r++) begin
      wr(8'h90, (r == 0) ? 32'h0 : (r == 1) ? 32'hF : (r == 2) ? 32'hA : 32'h3);
      for (int w = 0; w < 16; w++) begin
        wfi_in = w[3:0];
        @(negedge clk);
        @(negedge clk);
        chk(wfi_gated === (pwr_status & w[3:0]), "R2 directed gate", 256'(wfi_gated), 256'(pwr_status & w[3:0]));
      end
    end
    // R4 writing the same value keeps status
    wr(8'h90, 32'h3);
    chk(pwr_status === 4'h3, "R4 same-value write", 256'(pwr_status), 256'(3));
    wr(8'h90, 32'h6);
    chk(pwr_status === 4'h6, "R4 changed write", 256'(pwr_status), 256'(6));
    // R5 vectors
    wr(8'h50, 32'h1234_5678);
    wr(8'h54, 32'h0000_00AB);
    chk(reset_vec[2*64 +: 64] === 64'h0000_00AB_1234_5678, "R5 core2 vector", 256'(reset_vec[2*64 +: 64]), 256'(64'h000000AB12345678));
    wr(8'h4C, 32'hCAFE_0001);
    rd(8'h4C, 32'hCAFE_0001, "R5 core1 high readback");
    // R6 status register read-only bits
    wr(8'h94, 32'hFFFF_FFFF);
    rd(8'h94, 32'hFFFC_FFF6, "R6 pstat ro mask");
    wr(8'h94, 32'h0003_000F);
    rd(8'h94, 32'h0000_0006, "R6 pstat ro ignored");
    // R7 mask set/clear
    wr(8'h14, 32'h0);
    rd(8'h14, 32'h1, "R7 mask direct write ignored");
    wr(8'h18, 32'h1);
    rd(8'h14, 32'h0, "R7 mask cleared");
    rd(8'h18, 32'h0, "R7 clear reg reads zero");
    wr(8'h1C, 32'h1);
    rd(8'h14, 32'h1, "R7 mask set");
    rd(8'h10, 32'h0, "R7 status reads zero");
    // R8 plain registers
    wr(8'h00, 32'hA5A5_0001); rd(8'h00, 32'hA5A5_0001, "R8 err");
    wr(8'h24, 32'h0BAD_F00D); rd(8'h24, 32'h0BAD_F00D, "R8 cfg1");
    wr(8'h64, 32'h8000_0001); rd(8'h64, 32'h8000_0001, "R8 snoop");
    wr(8'h20, 32'h0000_0123); rd(8'h20, 32'h0000_0123, "R8 cfg0");
    // R10 misaligned and unmapped
    wr(8'h91, 32'h0);
    chk(pwr_status === 4'h6, "R10 misaligned write ignored", 256'(pwr_status), 256'(6));
    wr(8'h42, 32'h0);
    rd(8'h40, 32'hFFFF0000, "R10 misaligned vector write ignored");
    rd(8'h21, 32'h0, "R10 misaligned read");
    rd(8'h80, 32'h0, "R10 unmapped read");
    // R9 back-to-back reads
    req_valid = 1; req_write = 0; req_addr = 8'h60;
    @(negedge clk);
    req_addr = 8'h90;
    #1 chk(rd_valid === 1 && rd_data === 32'h000F000F, "R9 first of pair", 256'(rd_data), 256'(32'h000F000F));
    @(negedge clk);
    req_valid = 0;
    #1 chk(rd_valid === 1 && rd_data === 32'h6, "R9 second of pair", 256'(rd_data), 256'(6));
    @(negedge clk);
    #1 chk(rd_valid === 0, "R9 valid drops", 256'(rd_valid), 256'(0));
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule